// File: doc/BRIEF.md
# Cross-Clock Mailbox Bypass Register

This block carries one data word from a sending port to a receiving port. The word does not pass through the FIFO storage that sits between the same two ports. The sender drives a FIFO-style port: chip select, a direction bit, an enable and a mailbox-select bit. When all four call for a mailbox write, the word is stored in a dedicated register on the sender's clock. The receiver sees a mail-full flag on its own clock. While that flag is high it reads the word. A mailbox read on the receiver's clock clears the flag.

The flag is set in the sender's domain and cleared in the receiver's domain. The two domains talk through a toggle handshake. The sender flips a request bit and the receiver flips an acknowledge bit. Each bit reaches the opposite domain through a chain of synchronizing flops, and the number of flops is a parameter. The sender also has a busy flag. It stays high from the accepted write until the acknowledge comes back. While busy is high the stored word is frozen and further mail writes are dropped.

One asynchronous reset, shared with the companion FIFO, empties the mailbox in both domains. This block carries one direction only. A second instance serves the opposite direction.

Top module: `mbx_bypass`

## Requirements
- R1: While reset is low and right after it is released, rd_full is 0, wr_busy is 0 and rd_data is all zeros.
- R2: A mail write happens on a wr_clk edge where wr_sel, wr_en and wr_mbx are 1, wr_dir is 1 (1 = write) and wr_busy is 0. That edge captures wr_data, which later appears on rd_data.
- R3: If any of wr_sel, wr_en or wr_mbx is 0, or wr_dir is 0, no mail is stored. wr_busy and rd_full both stay 0.
- R4: wr_busy is 1 from the wr_clk edge after an accepted write until the acknowledge returns.
- R5: rd_full goes to 1 no later than three rd_clk edges after the accepted write. It then stays 1 until a mailbox read.
- R6: A mailbox read is an rd_clk edge where rd_sel, rd_en and rd_mbx are 1, rd_dir is 0 (0 = read) and rd_full is 1. rd_full is 0 right after that edge.
- R7: A mail write attempted while wr_busy is 1 is ignored. rd_data keeps the stored word, and no second mail appears after the read.
- R8: After a mailbox read, wr_busy returns to 0 within four wr_clk edges. A new write is then accepted.
- R9: A read strobe while rd_full is 0 has no effect. A later write still raises rd_full with the new word.
- R10: Asserting reset while mail is pending clears rd_full, wr_busy and the stored word.
- R11: rd_data does not change while wr_busy or rd_full is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Sender clock |
| rd_clk | input | 1 | Receiver clock, asynchronous to wr_clk |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_sel | input | 1 | Sender chip select, active high |
| wr_dir | input | 1 | Sender direction, 1 = write |
| wr_en | input | 1 | Sender enable, active high |
| wr_mbx | input | 1 | Sender mailbox select, active high |
| wr_data | input | DATA_W | Word to post |
| wr_busy | output | 1 | Sender-side view: mail pending, new writes dropped |
| rd_sel | input | 1 | Receiver chip select, active high |
| rd_dir | input | 1 | Receiver direction, 0 = read |
| rd_en | input | 1 | Receiver enable, active high |
| rd_mbx | input | 1 | Receiver mailbox select, active high |
| rd_full | output | 1 | Receiver-side new-mail flag |
| rd_data | output | DATA_W | Stored mail word |

## Verification
The main path is driven with several words: all zeros, all ones, and both alternating patterns. It is also driven with walking-one words, which would expose a bit that is dropped or swapped between capture and rd_data. Strobe patterns with exactly one qualifier missing, or with the direction reversed, tell a correct four-way decode apart from a partial one. A write retried while busy shows whether the stored word is protected and whether a phantom second mail is created. A read strobe on an empty mailbox, followed by a normal exchange, shows that the acknowledge toggles only on a real read. A reset in the middle of a pending exchange shows that both domains return to empty together.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   localparam logic DIR_WRITE = 1'b1;
   localparam logic DIR_READ  = 1'b0;

   typedef struct packed {
      logic sel;
      logic dir;
      logic en;
      logic mbx;
   } mbx_port_t;

   function automatic logic mbx_hit(input mbx_port_t p, input logic want_dir);
      return p.sel & p.en & p.mbx & (p.dir == want_dir);
   endfunction
endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("mbx_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[gi] <= 1'b0;
               else        chain[gi] <= chain[gi-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/mbx_wr_side.sv
module mbx_wr_side
   import mbx_pkg::*;
#(
   parameter int DATA_W      = 36,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  mbx_port_t         port,
   input  logic [DATA_W-1:0] data_in,
   input  logic              ack_tgl,
   output logic              req_tgl,
   output logic [DATA_W-1:0] mail_q,
   output logic              busy
);
   logic ack_seen;
   logic accept;

   mbx_sync #(.STAGES(SYNC_STAGES)) i_ack_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (ack_tgl),
      .q     (ack_seen)
   );

   assign busy   = req_tgl ^ ack_seen;
   assign accept = mbx_hit(port, DIR_WRITE) & ~busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_tgl <= 1'b0;
         mail_q  <= '0;
      end else if (accept) begin
         req_tgl <= ~req_tgl;
         mail_q  <= data_in;
      end
   end

   p_busy_after_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> busy);
   p_hold_word_r11: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(mail_q));
   p_drop_when_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(req_tgl));
endmodule

// File: rtl/mbx_rd_side.sv
module mbx_rd_side
   import mbx_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  mbx_port_t port,
   input  logic      req_tgl,
   output logic      ack_tgl,
   output logic      full
);
   logic req_seen;
   logic take;

   mbx_sync #(.STAGES(SYNC_STAGES)) i_req_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (req_tgl),
      .q     (req_seen)
   );

   assign full = req_seen ^ ack_tgl;
   assign take = mbx_hit(port, DIR_READ) & full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ack_tgl <= 1'b0;
      else if (take) ack_tgl <= ~ack_tgl;
   end

   p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> !full);
   p_full_persists_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !take) |=> full);
   p_empty_read_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !full |=> $stable(ack_tgl));
endmodule

// File: rtl/mbx_bypass.sv
module mbx_bypass
   import mbx_pkg::*;
#(
   parameter int DATA_W      = 36,
   parameter int SYNC_STAGES = 2
) (
   input  logic              wr_clk,
   input  logic              rd_clk,
   input  logic              rst_n,
   input  logic              wr_sel,
   input  logic              wr_dir,
   input  logic              wr_en,
   input  logic              wr_mbx,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_busy,
   input  logic              rd_sel,
   input  logic              rd_dir,
   input  logic              rd_en,
   input  logic              rd_mbx,
   output logic              rd_full,
   output logic [DATA_W-1:0] rd_data
);
   generate
      if (DATA_W < 1) begin : g_bad_w
         $error("mbx_bypass: DATA_W must be positive");
      end
   endgenerate

   mbx_port_t         wport, rport;
   logic              req_tgl, ack_tgl;
   logic [DATA_W-1:0] mail_q;

   assign wport = '{sel: wr_sel, dir: wr_dir, en: wr_en, mbx: wr_mbx};
   assign rport = '{sel: rd_sel, dir: rd_dir, en: rd_en, mbx: rd_mbx};

   mbx_wr_side #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) i_wr (
      .clk     (wr_clk),
      .rst_n   (rst_n),
      .port    (wport),
      .data_in (wr_data),
      .ack_tgl (ack_tgl),
      .req_tgl (req_tgl),
      .mail_q  (mail_q),
      .busy    (wr_busy)
   );

   mbx_rd_side #(.SYNC_STAGES(SYNC_STAGES)) i_rd (
      .clk     (rd_clk),
      .rst_n   (rst_n),
      .port    (rport),
      .req_tgl (req_tgl),
      .ack_tgl (ack_tgl),
      .full    (rd_full)
   );

   assign rd_data = mail_q;

   p_full_word_stable_r11: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (rd_full && $past(rd_full)) |-> $stable(rd_data));
endmodule

// File: tb/test_mbx_bypass.sv
module test_mbx_bypass;
   localparam int W = 36;

   logic wr_clk = 0, rd_clk = 0, rst_n = 0;
   logic wr_sel = 0, wr_dir = 0, wr_en = 0, wr_mbx = 0;
   logic [W-1:0] wr_data = '0;
   logic rd_sel = 0, rd_dir = 1, rd_en = 0, rd_mbx = 0;
   logic wr_busy, rd_full;
   logic [W-1:0] rd_data;

   int n_cmp = 0, n_bad = 0;
   bit pending = 0;
   logic [W-1:0] exp_word = '0;
   bit done = 0;

   always #10 wr_clk = ~wr_clk;
   always #7  rd_clk = ~rd_clk;

   mbx_bypass #(.DATA_W(W), .SYNC_STAGES(2)) i_mbx_bypass (
      .wr_clk, .rd_clk, .rst_n,
      .wr_sel, .wr_dir, .wr_en, .wr_mbx, .wr_data, .wr_busy,
      .rd_sel, .rd_dir, .rd_en, .rd_mbx, .rd_full, .rd_data
   );

   task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // per-clock reference comparison
   always @(negedge rd_clk) if (rst_n && !done) begin
      if (rd_full) begin
         chk(pending, "R7 no phantom mail", rd_full, pending);
         chk(rd_data == exp_word, "R11 word while full", rd_data, exp_word);
      end
   end
   always @(negedge wr_clk) if (rst_n && !done) begin
      if (pending) chk(wr_busy == 1'b1, "R4 busy while pending", wr_busy, 1);
   end

   task automatic do_write(input logic [W-1:0] d, input logic s, input logic dr, input logic e, input logic m);
      @(negedge wr_clk);
      wr_sel = s; wr_dir = dr; wr_en = e; wr_mbx = m; wr_data = d;
      @(negedge wr_clk);
      wr_sel = 0; wr_dir = 0; wr_en = 0; wr_mbx = 0;
   endtask

   task automatic post(input logic [W-1:0] d);
      bit seen = 0;
      do_write(d, 1, 1, 1, 1);
      pending = 1; exp_word = d;
      chk(wr_busy == 1, "R4 busy after accept", wr_busy, 1);
      for (int i = 0; i <= 3 && !seen; i++) begin
         if (i > 0) @(negedge rd_clk);
         if (rd_full) seen = 1;
      end
      chk(seen, "R5 full within three reader clocks", seen, 1);
      chk(rd_data == d, "R2 captured word", rd_data, d);
   endtask

   task automatic strobe_read();
      @(negedge rd_clk);
      rd_sel = 1; rd_dir = 0; rd_en = 1; rd_mbx = 1;
      @(negedge rd_clk);
      rd_sel = 0; rd_dir = 1; rd_en = 0; rd_mbx = 0;
   endtask

   task automatic collect();
      bit cleared = 0;
      @(negedge rd_clk);
      rd_sel = 1; rd_dir = 0; rd_en = 1; rd_mbx = 1;
      @(posedge rd_clk);
      pending = 0;
      @(negedge rd_clk);
      rd_sel = 0; rd_dir = 1; rd_en = 0; rd_mbx = 0;
      chk(rd_full == 0, "R6 read clears full", rd_full, 0);
      for (int i = 0; i < 4 && !cleared; i++) begin
         @(negedge wr_clk);
         if (!wr_busy) cleared = 1;
      end
      chk(cleared, "R8 busy clears after read", cleared, 1);
   endtask

   task automatic expect_quiet(input string req);
      for (int i = 0; i < 6; i++) begin
         @(negedge rd_clk);
         chk(rd_full == 0, req, rd_full, 0);
      end
      chk(wr_busy == 0, req, wr_busy, 0);
   endtask

   initial begin
      #200000;
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #35;
      chk(rd_full == 0 && wr_busy == 0 && rd_data == 0, "R1 in reset", {rd_full, wr_busy}, 0);
      repeat (3) @(negedge wr_clk);
      rst_n = 1;
      @(negedge rd_clk);
      chk(rd_full == 0 && wr_busy == 0 && rd_data == 0, "R1 after reset", rd_data, 0);

      // R2 R5 R6 R8: data patterns
      post('0);                collect();
      post({W{1'b1}});         collect();
      post(36'hA_AAAA_AAAA);   collect();
      post(36'h5_5555_5555);   collect();
      for (int b = 0; b < W; b += 7) begin
         post(36'd1 << b);     collect();
      end

      // R3: each qualifier missing or direction reversed
      do_write(36'h1_2345_6789, 0, 1, 1, 1); expect_quiet("R3 no select");
      do_write(36'h1_2345_6789, 1, 0, 1, 1); expect_quiet("R3 read direction");
      do_write(36'h1_2345_6789, 1, 1, 0, 1); expect_quiet("R3 no enable");
      do_write(36'h1_2345_6789, 1, 1, 1, 0); expect_quiet("R3 no mailbox select");

      // R7: write while busy ignored
      post(36'h0_DEAD_BEEF);
      do_write(36'hF_0000_0001, 1, 1, 1, 1);
      repeat (2) @(negedge rd_clk);
      chk(rd_data == 36'h0_DEAD_BEEF, "R7 stored word kept", rd_data, 36'h0_DEAD_BEEF);
      collect();
      expect_quiet("R7 no second mail");

      // R9: read on empty mailbox
      strobe_read();
      expect_quiet("R9 empty read idle");
      post(36'h3_C3C3_C3C3);
      collect();

      // R10: reset with mail pending
      post(36'h7_7777_0000);
      @(negedge rd_clk);
      rst_n = 0; pending = 0;
      #3;
      chk(rd_full == 0 && wr_busy == 0, "R10 reset clears flags", {rd_full, wr_busy}, 0);
      chk(rd_data == 0, "R10 reset clears word", rd_data, 0);
      repeat (2) @(negedge wr_clk);
      rst_n = 1;
      expect_quiet("R10 stays empty");
      post(36'h9_8765_4321);
      collect();

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule